// File: doc/BRIEF.md
# Dual Masked Alarm Interrupt Unit

This block watches a BCD time of day supplied by a separate timekeeper and raises interrupts when it matches either of two programmable alarms. Each alarm holds four compare bytes (seconds, minutes, hours, day of week). Bit 7 of every compare byte is a don't-care mask, so the same hardware can fire once a week, once a day, once an hour, once a minute or once a second. The comparison runs only on the once-per-second strobe. A match sets a per-alarm request flag that stays set until software touches any compare byte of that alarm.

The two alarms drive outputs of different kinds. Alarm 0 gives an active-low level that stays asserted while its flag and enable are both set. Alarm 1 gives an active-high pulse of fixed length, timed in cycles of a 32.768 kHz enable and restarted by every new qualifying match. A third control bit gates a 1 Hz square wave that restarts its phase on every seconds strobe. Software reaches the compare bytes, the control byte and the status byte through a flat strobe-based register port with combinational read data.

Register addresses: 0 to 3 are alarm 0 (seconds, minutes, hours, day), 4 to 7 are alarm 1 in the same order, 8 is control and 9 is status. Every other address reads zero.

Top module: `dual_alarm_irq`

## Requirements
- R1: After reset all compare bytes and the control byte read 0, the status byte reads 0, `irq0_n` is 1, `irq1` is 0, `sqw_oe` is 0 and `sqw_out` is 0.
- R2: Compare bytes (addresses 0 to 7) and the control byte (address 8, bits 2:0, bits 7:3 read 0) read back what was written; status (address 9) carries the alarm 0 flag in bit 0 and the alarm 1 flag in bit 1 with bits 7:2 at 0; writes to address 9 and accesses to addresses 10 to 15 change nothing, and those addresses read 0.
- R3: A compare field matches when its bit 7 is 1, or when its bits 6:0 equal bits 6:0 of the current time field; an alarm matches only when all four fields match.
- R4: The mask bits give the repeat rates: none masked fires on one weekly time, day masked fires daily, day and hours masked hourly, day, hours and minutes masked every minute, all four masked on every seconds strobe.
- R5: The comparison is made only in a cycle with `sec_tick` high; a flag never rises in a cycle after one with `sec_tick` low.
- R6: A read strobe or write strobe to any compare byte of an alarm clears that alarm's flag on the same edge, and leaves the other alarm's flag unchanged.
- R7: When a flag-clearing access and a new match of the same alarm fall in the same cycle, the flag ends set.
- R8: `irq0_n` is 0 exactly while the alarm 0 flag is set and control bit 0 is 1, changing in the cycle after the edge that changed either.
- R9: A match of alarm 1 while control bit 1 is 1 drives `irq1` high from the next cycle for `PULSE_TICKS` cycles of `tick_32k`, and a new qualifying match restarts the count; while control bit 1 is 0, `irq1` is 0 and the pulse count is dropped.
- R10: Control bit 2 drives `sqw_oe`; while it is 0, `sqw_out` is 0; while it is 1, `sqw_out` is 1 for the first `TICKS_PER_SEC/2` `tick_32k` counts after each `sec_tick` and 0 for the rest, the phase wrapping after `TICKS_PER_SEC` counts.
- R11: The hours compare uses all of bits 6:0, so the 12/24-hour select (bit 6) and the PM bit (bit 5) take part in the match like the digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe when the time advances by a second |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD with 12/24 and PM bits |
| cur_dow | input | 8 | Current day of week |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq0_n | output | 1 | Alarm 0 interrupt, active-low level |
| irq1 | output | 1 | Alarm 1 interrupt, active-high timed pulse |
| sqw_out | output | 1 | 1 Hz square wave |
| sqw_oe | output | 1 | Output enable for the square-wave pad |

## Verification
A wrong flag shows on the status byte and, when enabled, on `irq0_n` in the very next cycle, so a flag that fails to set, fails to clear, or is cleared by the wrong alarm's access is visible one edge after the cause. A pulse counter that loads the wrong length or misses a restart shows as `irq1` falling early or late by a whole number of `tick_32k` enables, and a square-wave phase that is not restarted shows as `sqw_out` out of step right after a seconds strobe. The bench therefore compares every output against a behavioural model on every clock, which catches each of these at the first cycle it diverges.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int ALARM_COUNT     = 2;
    localparam int FIELDS          = 4;
    localparam int DATA_W          = 8;
    localparam int REG_AW          = 4;
    localparam int FIELD_SEL_W     = $clog2(FIELDS);
    localparam int SLOT_SEL_W      = REG_AW - FIELD_SEL_W;

    localparam logic [REG_AW-1:0] ADDR_CTRL = REG_AW'(ALARM_COUNT * FIELDS);
    localparam logic [REG_AW-1:0] ADDR_STAT = REG_AW'(ALARM_COUNT * FIELDS + 1);

    localparam int MASK_BIT = DATA_W - 1;

    typedef logic [FIELDS-1:0][DATA_W-1:0] alarm_bytes_t;

    typedef struct packed {
        logic sqw_en;
        logic en1;
        logic en0;
    } ctrl_t;

endpackage

// File: rtl/alarm_slot.sv
module alarm_slot
    import alarm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sec_tick,
    input  alarm_bytes_t           cur_time,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [FIELD_SEL_W-1:0] field_sel,
    input  logic [DATA_W-1:0]      wdata,
    output alarm_bytes_t           cfg_o,
    output logic                   match_o,
    output logic                   flag_o
);

    typedef struct packed {
        alarm_bytes_t cfg;
        logic         flag;
    } slot_state_t;

    slot_state_t state_d, state_q;
    logic [FIELDS-1:0] field_ok;

    generate
        for (genvar f = 0; f < FIELDS; f++) begin : g_field
            assign field_ok[f] = state_q.cfg[f][MASK_BIT] ||
                                 (state_q.cfg[f][MASK_BIT-1:0] == cur_time[f][MASK_BIT-1:0]);
        end
    endgenerate

    assign match_o = sec_tick && (&field_ok);

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.cfg[field_sel] = wdata;
        end
        if (match_o) begin
            state_d.flag = 1'b1;
        end else if (wr_en || rd_en) begin
            state_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_o  = state_q.cfg;
    assign flag_o = state_q.flag;

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int PULSE_TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trigger,
    input  logic tick,
    output logic active
);

    localparam int CNT_W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } pulse_state_t;

    pulse_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d.remain = '0;
        end else if (trigger) begin
            state_d.remain = CNT_W'(PULSE_TICKS);
        end else if (tick && (state_q.remain != '0)) begin
            state_d.remain = state_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign active = enable && (state_q.remain != '0);

endmodule

// File: rtl/square_wave_gen.sv
module square_wave_gen #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic tick,
    output logic level
);

    localparam int PH_W = $clog2(TICKS_PER_SEC);
    localparam logic [PH_W-1:0] LAST = PH_W'(TICKS_PER_SEC - 1);
    localparam logic [PH_W-1:0] HALF = PH_W'(TICKS_PER_SEC / 2);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } sqw_state_t;

    sqw_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (sec_tick) begin
            state_d.phase = '0;
        end else if (tick) begin
            state_d.phase = (state_q.phase == LAST) ? '0 : state_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign level = state_q.phase < HALF;

endmodule

// File: rtl/dual_alarm_irq.sv
module dual_alarm_irq
    import alarm_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int PULSE_TICKS   = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              tick_32k,
    input  logic [DATA_W-1:0] cur_sec,
    input  logic [DATA_W-1:0] cur_min,
    input  logic [DATA_W-1:0] cur_hour,
    input  logic [DATA_W-1:0] cur_dow,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq0_n,
    output logic              irq1,
    output logic              sqw_out,
    output logic              sqw_oe
);

    typedef struct packed {
        ctrl_t ctrl;
    } top_state_t;

    top_state_t state_d, state_q;

    alarm_bytes_t                     cur_time;
    logic                             in_alarm;
    logic [SLOT_SEL_W-1:0]            slot_sel;
    logic [FIELD_SEL_W-1:0]           field_sel;
    logic [ALARM_COUNT-1:0]           slot_wr;
    logic [ALARM_COUNT-1:0]           slot_rd;
    logic [ALARM_COUNT-1:0]           slot_match;
    logic [ALARM_COUNT-1:0]           flag_q;
    alarm_bytes_t [ALARM_COUNT-1:0]   slot_cfg;
    logic                             pulse_active;
    logic                             sqw_level;

    assign cur_time  = {cur_dow, cur_hour, cur_min, cur_sec};
    assign in_alarm  = reg_addr < ADDR_CTRL;
    assign slot_sel  = reg_addr[REG_AW-1:FIELD_SEL_W];
    assign field_sel = reg_addr[FIELD_SEL_W-1:0];

    generate
        for (genvar k = 0; k < ALARM_COUNT; k++) begin : g_slot
            localparam logic [SLOT_SEL_W-1:0] IDX = SLOT_SEL_W'(k);
            assign slot_wr[k] = reg_wr && in_alarm && (slot_sel == IDX);
            assign slot_rd[k] = reg_rd && in_alarm && (slot_sel == IDX);

            alarm_slot u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .sec_tick  (sec_tick),
                .cur_time  (cur_time),
                .wr_en     (slot_wr[k]),
                .rd_en     (slot_rd[k]),
                .field_sel (field_sel),
                .wdata     (reg_wdata),
                .cfg_o     (slot_cfg[k]),
                .match_o   (slot_match[k]),
                .flag_o    (flag_q[k])
            );
        end
    endgenerate

    pulse_timer #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (state_q.ctrl.en1),
        .trigger (slot_match[1]),
        .tick    (tick_32k),
        .active  (pulse_active)
    );

    square_wave_gen #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_sqw (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .tick     (tick_32k),
        .level    (sqw_level)
    );

    always_comb begin
        state_d = state_q;
        if (reg_wr && (reg_addr == ADDR_CTRL)) begin
            state_d.ctrl = ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_alarm) begin
            for (int k = 0; k < ALARM_COUNT; k++) begin
                if (slot_sel == SLOT_SEL_W'(k)) begin
                    reg_rdata = slot_cfg[k][field_sel];
                end
            end
        end else if (reg_addr == ADDR_CTRL) begin
            reg_rdata = DATA_W'(state_q.ctrl);
        end else if (reg_addr == ADDR_STAT) begin
            reg_rdata = DATA_W'(flag_q);
        end
    end

    assign irq0_n  = !(flag_q[0] && state_q.ctrl.en0);
    assign irq1    = pulse_active;
    assign sqw_oe  = state_q.ctrl.sqw_en;
    assign sqw_out = state_q.ctrl.sqw_en && sqw_level;

endmodule

// File: rtl/dual_alarm_irq_chk.sv
module dual_alarm_irq_chk
    import alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq0_n,
    input logic              irq1,
    input logic              sqw_out,
    input logic              sqw_oe,
    input logic [1:0]        flag_q
);

    // R5: no flag rises without a seconds strobe in the previous cycle
    p_flag_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> !$rose(flag_q[0]) && !$rose(flag_q[1]));

    // R6: an access to alarm 0 bytes with no match clears its flag
    p_access_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rd || reg_wr) && (reg_addr < REG_AW'(FIELDS)) && !sec_tick) |=> !flag_q[0]);

    // R2: upper status bits are always zero
    p_status_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STAT) |-> (reg_rdata[DATA_W-1:2] == '0));

    // R8: interrupt 0 only asserts after a seconds strobe or a control write
    p_irq0_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq0_n) |-> $past(sec_tick || (reg_wr && (reg_addr == ADDR_CTRL))));

    // R9: the pulse output only starts after a seconds strobe
    p_irq1_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> !$rose(irq1));

    // R10: disabled square wave stays low
    p_sqw_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_oe |-> !sqw_out);

endmodule

bind dual_alarm_irq dual_alarm_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq0_n    (irq0_n),
    .irq1      (irq1),
    .sqw_out   (sqw_out),
    .sqw_oe    (sqw_oe),
    .flag_q    (flag_q)
);

// File: tb/dual_alarm_irq_tb_top.sv
module dual_alarm_irq_tb_top;

    localparam int TPS   = 16;
    localparam int PULSE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       tick_32k = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00, cur_dow = 8'h00;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq0_n, irq1, sqw_out, sqw_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_alarm_irq #(.TICKS_PER_SEC(TPS), .PULSE_TICKS(PULSE)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tick_32k(tick_32k),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq0_n(irq0_n), .irq1(irq1),
        .sqw_out(sqw_out), .sqw_oe(sqw_oe)
    );

    // ---------------- behavioural reference model ----------------
    int m_alarm [2][4];
    int m_ctrl;
    bit m_flag [2];
    int m_remain;
    int m_phase;

    function automatic bit field_hit(int cfg, logic [7:0] cur);
        return (cfg >= 128) || ((cfg % 128) == int'(cur[6:0]));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_alarm[a, f]) m_alarm[a][f] = 0;
            m_ctrl = 0; m_flag[0] = 0; m_flag[1] = 0; m_remain = 0; m_phase = 0;
        end else begin
            bit hit [2];
            bit touch [2];
            bit en1_old;
            en1_old = (m_ctrl / 2) % 2 == 1;
            for (int a = 0; a < 2; a++) begin
                hit[a] = sec_tick && field_hit(m_alarm[a][0], cur_sec) &&
                         field_hit(m_alarm[a][1], cur_min) &&
                         field_hit(m_alarm[a][2], cur_hour) &&
                         field_hit(m_alarm[a][3], cur_dow);
                touch[a] = (reg_rd || reg_wr) && (int'(reg_addr) / 4 == a) && (reg_addr < 8);
            end
            for (int a = 0; a < 2; a++) begin
                if (hit[a]) m_flag[a] = 1;
                else if (touch[a]) m_flag[a] = 0;
            end
            if (!en1_old) m_remain = 0;
            else if (hit[1]) m_remain = PULSE;
            else if (tick_32k && m_remain > 0) m_remain--;
            if (sec_tick) m_phase = 0;
            else if (tick_32k) m_phase = (m_phase + 1) % TPS;
            if (reg_wr && reg_addr < 8) m_alarm[reg_addr / 4][reg_addr % 4] = int'(reg_wdata);
            if (reg_wr && reg_addr == 8) m_ctrl = int'(reg_wdata) % 8;
        end
    end

    function automatic int model_rdata();
        if (reg_addr < 8) return m_alarm[reg_addr / 4][reg_addr % 4];
        if (reg_addr == 8) return m_ctrl;
        if (reg_addr == 9) return int'(m_flag[0]) + 2 * int'(m_flag[1]);
        return 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int e0, e1, es, eo, er;
            e0 = !(m_flag[0] && (m_ctrl % 2 == 1));
            e1 = ((m_ctrl / 2) % 2 == 1) && (m_remain > 0);
            eo = (m_ctrl / 4) % 2;
            es = (eo == 1) && (m_phase < TPS / 2);
            er = model_rdata();
            check(int'(irq0_n) == e0, "R8 irq0_n", int'(irq0_n), e0);
            check(int'(irq1) == e1, "R9 irq1", int'(irq1), e1);
            check(int'(sqw_oe) == eo, "R10 sqw_oe", int'(sqw_oe), eo);
            check(int'(sqw_out) == es, "R10 sqw_out", int'(sqw_out), es);
            check(int'(reg_rdata) == er, "R2 rdata", int'(reg_rdata), er);
        end
    end

    // ---------------- stimulus helpers ----------------
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #4;
            cyc++;
            tick_32k = (cyc % 3) != 0;
        end
    end

    task automatic step();
        @(posedge clk); #4;
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
        step();
        reg_wr = 0;
    endtask

    task automatic rd(int a, output int d);
        reg_rd = 1; reg_addr = 4'(a);
        @(negedge clk); d = int'(reg_rdata);
        step();
        reg_rd = 0;
    endtask

    task automatic peek(int a, output int d);
        reg_addr = 4'(a);
        @(negedge clk); d = int'(reg_rdata);
        step();
    endtask

    task automatic tick(int s, int m, int h, int w);
        cur_sec = 8'(s); cur_min = 8'(m); cur_hour = 8'(h); cur_dow = 8'(w);
        sec_tick = 1;
        step();
        sec_tick = 0;
    endtask

    task automatic pins(string req, int e0, int e1);
        @(negedge clk);
        check(int'(irq0_n) == e0, req, int'(irq0_n), e0);
        check(int'(irq1) == e1, req, int'(irq1), e1);
        step();
    endtask

    task automatic expect_status(string req, int exp);
        int d;
        peek(9, d);
        check(d == exp, req, d, exp);
    endtask

    task automatic clear0();
        int d;
        rd(0, d);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int d;
        repeat (4) step();
        rst_n = 1;
        step();

        // R1 reset state
        expect_status("R1 status after reset", 0);
        rd(3, d); check(d == 0, "R1 alarm byte after reset", d, 0);
        pins("R1 irq pins after reset", 1, 0);
        @(negedge clk); check(sqw_oe == 0, "R1 sqw_oe after reset", int'(sqw_oe), 0); step();

        // R3 / R8 exact weekly match
        wr(8, 8'h01);
        wr(0, 8'h30); wr(1, 8'h15); wr(2, 8'h08); wr(3, 8'h03);
        tick(8'h30, 8'h15, 8'h08, 8'h03);
        pins("R8 irq0 asserted on match", 0, 0);
        expect_status("R3 exact match sets flag", 1);

        // R2 readback, R6 read clears
        rd(2, d); check(d == 8'h08, "R2 hours readback", d, 8'h08);
        expect_status("R6 read clears flag", 0);
        pins("R8 irq0 released", 1, 0);

        // R3 single field mismatch
        tick(8'h31, 8'h15, 8'h08, 8'h03);
        expect_status("R3 seconds mismatch", 0);

        // R11 12/24 and PM bits take part
        tick(8'h30, 8'h15, 8'h48, 8'h03);
        expect_status("R11 12h bit mismatch", 0);
        wr(2, 8'h68);
        tick(8'h30, 8'h15, 8'h48, 8'h03);
        expect_status("R11 AM vs PM mismatch", 0);
        tick(8'h30, 8'h15, 8'h68, 8'h03);
        expect_status("R11 12h PM match", 1);
        clear0();

        // R4 repeat rates
        wr(3, 8'h83);
        tick(8'h30, 8'h15, 8'h68, 8'h06);
        expect_status("R4 daily match on other day", 1);
        clear0();
        wr(2, 8'h80);
        tick(8'h30, 8'h15, 8'h11, 8'h01);
        expect_status("R4 hourly match", 1);
        tick(8'h30, 8'h16, 8'h11, 8'h01);
        clear0();
        tick(8'h30, 8'h16, 8'h11, 8'h01);
        expect_status("R4 hourly needs minutes", 0);
        wr(1, 8'h80);
        tick(8'h30, 8'h59, 8'h23, 8'h07);
        expect_status("R4 minute match", 1);
        clear0();
        wr(0, 8'h80);
        tick(8'h07, 8'h42, 8'h05, 8'h02);
        expect_status("R4 every second", 1);

        // R5 no tick no set
        clear0();
        repeat (5) step();
        expect_status("R5 no compare without tick", 0);

        // R7 set wins over clear
        reg_rd = 1; reg_addr = 4'd1; sec_tick = 1;
        step();
        reg_rd = 0; sec_tick = 0;
        expect_status("R7 match beats clear", 1);

        // R6 other alarm access does not clear alarm 0
        rd(4, d);
        expect_status("R6 alarm1 read keeps flag0", 1);

        // R9 pulse
        wr(4, 8'h80); wr(5, 8'h80); wr(6, 8'h80); wr(7, 8'h80);
        wr(8, 8'h03);
        tick(8'h01, 8'h01, 8'h01, 8'h01);
        pins("R9 pulse starts", 0, 1);
        expect_status("R9 both flags", 3);
        repeat (20) step();
        pins("R9 pulse ends", 0, 0);
        tick(8'h02, 8'h01, 8'h01, 8'h01);
        repeat (8) step();
        tick(8'h03, 8'h01, 8'h01, 8'h01);
        repeat (8) step();
        pins("R9 pulse restarted", 0, 1);
        wr(8, 8'h01);
        pins("R9 disabled forces low", 0, 0);
        tick(8'h04, 8'h01, 8'h01, 8'h01);
        pins("R9 no pulse while disabled", 0, 0);
        wr(8, 8'h03);
        repeat (2) step();
        pins("R9 re-enable does not resume pulse", 0, 0);

        // R10 square wave
        wr(8, 8'h04);
        @(negedge clk); check(sqw_oe == 1, "R10 oe follows enable", int'(sqw_oe), 1); step();
        tick(8'h05, 8'h01, 8'h01, 8'h01);
        @(negedge clk); check(sqw_out == 1, "R10 high after strobe", int'(sqw_out), 1); step();
        repeat (30) step();
        wr(8, 8'h00);
        @(negedge clk); check(sqw_out == 0, "R10 gated low", int'(sqw_out), 0); step();

        // R2 status write ignored, unused address reads zero
        wr(9, 8'hFF);
        expect_status("R2 status write ignored", 3);
        peek(12, d); check(d == 0, "R2 unused address", d, 0);
        wr(8, 8'hFF);
        rd(8, d); check(d == 7, "R2 control upper bits", d, 7);

        repeat (3) step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule